// File: doc/BRIEF.md
# Clock-Enable Low-Power Mode Controller

This block tracks the low-power modes that a DDR SDRAM enters and leaves through its clock-enable pin. Each rising clock edge it samples the clock-enable level, a decoded command code and an all-banks-idle indication. It compares the clock-enable level with the level it registered on the previous edge, and from that pair it decides on power-down or self-refresh entry and exit. It also enforces the hold-off after power-up and the wait that follows a low-power exit.

It reports the current mode and a command-accept enable that is high only in normal operation. It also drives a request to keep the data and strobe pins at high impedance, and a one-cycle illegal pulse for any command that the clock-enable rules forbid. The power-up hold length and both exit waits are parameters, counted in clocks. The surrounding controller uses the accept enable to gate its command decoder and the high-impedance request to gate its pin drivers.

Top module: `cke_lpm_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the mode is power-up wait (mode code 0), the accept enable is 0, the illegal flag is 0 and the high-impedance request is 1.
- R2: The mode moves from power-up wait to normal (code 1) on the edge that completes PWRUP_HOLD consecutive cycles with clock-enable high and the deselect command (code 0). Any other cycle restarts the count.
- R3: In normal mode, clock-enable high on the previous edge and low now, together with a no-op (code 1) or deselect (code 0), enters power down (code 2).
- R4: In normal mode, a clock-enable fall together with refresh (code 2) while all banks are idle enters self refresh (code 3).
- R5: A clock-enable fall in normal mode with any command code from 3 to 7, or with refresh while a bank is not idle, gives a one-cycle illegal pulse on the next cycle and leaves the mode in normal.
- R6: In power down or self refresh, the mode stays unchanged and no illegal pulse arises while clock-enable stays low, whatever the command.
- R7: A clock-enable rise in power down enters exit wait (code 4). The mode becomes normal so that a command issued PD_EXIT cycles after the rising cycle is accepted.
- R8: A clock-enable rise in self refresh enters exit wait. The mode becomes normal only SR_EXIT cycles after the rising cycle.
- R9: A command other than no-op or deselect on the clock-enable rising cycle, or during exit wait, gives an illegal pulse on the next cycle. The exit wait still runs to its end.
- R10: The high-impedance request is 1 on every cycle after an edge that sampled clock-enable low, and throughout power-up wait. It is 0 otherwise.
- R11: The accept enable is 1 exactly when the mode is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_i | input | 1 | Sampled clock-enable level |
| cmd_i | input | 3 | Decoded command: 0 deselect, 1 no-op, 2 refresh, 3 activate, 4 read, 5 write, 6 precharge, 7 mode set |
| all_idle_i | input | 1 | All banks idle |
| mode_o | output | 3 | Mode: 0 power-up wait, 1 normal, 2 power down, 3 self refresh, 4 exit wait |
| cmd_accept_o | output | 1 | Commands may be accepted |
| dq_hiz_o | output | 1 | Hold data and strobe pins at high impedance |
| illegal_o | output | 1 | One-cycle pulse for a forbidden command |

## Verification
Two functions can land in the same cycle. A clock-enable rise that carries a forbidden command starts the exit wait and raises the illegal flag together. Likewise, a clock-enable fall with refresh while a bank is busy must flag illegal rather than enter self refresh. The stimulus table applies an activate on the self-refresh rising edge and a refresh fall with the idle input low. After each, it checks the mode and the illegal flag at the same sample point. A read injected midway through the long self-refresh wait then confirms that the wait keeps counting and ends on the expected edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL   = 3'd0,
        CMD_NOP     = 3'd1,
        CMD_REFRESH = 3'd2,
        CMD_ACT     = 3'd3,
        CMD_READ    = 3'd4,
        CMD_WRITE   = 3'd5,
        CMD_PRE     = 3'd6,
        CMD_MODESET = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        MODE_PWRUP  = 3'd0,
        MODE_NORMAL = 3'd1,
        MODE_PDOWN  = 3'd2,
        MODE_SREF   = 3'd3,
        MODE_EXIT   = 3'd4
    } mode_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } cke_ev_t;

    function automatic logic is_quiet(cmd_e c);
        return (c == CMD_DESEL) || (c == CMD_NOP);
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lpm_cke_track.sv
module lpm_cke_track
    import lpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cke_i,
    output cke_ev_t ev_o,
    output logic    prev_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cke_i;
    end

    always_comb begin
        ev_o.level = cke_i;
        ev_o.rise  = cke_i & ~prev_q;
        ev_o.fall  = ~cke_i & prev_q;
    end

    assign prev_o = prev_q;
endmodule

// File: rtl/lpm_span_cnt.sv
module lpm_span_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         at_limit
);
    logic [W-1:0] cnt_q;

    assign at_limit = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear)          cnt_q <= '0;
        else if (step && !at_limit) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cke_lpm_ctrl.sv
module cke_lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int PWRUP_HOLD = 200,
    parameter int PD_EXIT    = 2,
    parameter int SR_EXIT    = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cke_i,
    input  logic [2:0] cmd_i,
    input  logic       all_idle_i,
    output logic [2:0] mode_o,
    output logic       cmd_accept_o,
    output logic       dq_hiz_o,
    output logic       illegal_o
);
    // Exit waits must be at least 2 and the hold at least 1.
    localparam int SPAN_MAX = max3(PWRUP_HOLD, PD_EXIT, SR_EXIT);
    localparam int CW       = $clog2(SPAN_MAX + 1);
    localparam logic [CW-1:0] PU_LIM = CW'(PWRUP_HOLD - 1);
    localparam logic [CW-1:0] PD_LIM = CW'(PD_EXIT - 2);
    localparam logic [CW-1:0] SR_LIM = CW'(SR_EXIT - 2);

    mode_e   mode_q, mode_d;
    logic    ill_q, ill_d;
    logic    exit_sr_q, exit_sr_d;
    cke_ev_t ev;
    logic    cke_prev;
    cmd_e    cmd;
    logic    quiet;

    assign cmd   = cmd_e'(cmd_i);
    assign quiet = is_quiet(cmd);

    lpm_cke_track u_track (
        .clk    (clk),
        .rst    (rst),
        .cke_i  (cke_i),
        .ev_o   (ev),
        .prev_o (cke_prev)
    );

    // Power-up hold: consecutive cycles of clock-enable high with deselect.
    logic pu_step, pu_done;
    assign pu_step = (mode_q == MODE_PWRUP) && ev.level && (cmd == CMD_DESEL);

    lpm_span_cnt #(.W(CW)) u_pu_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (!pu_step),
        .step     (pu_step),
        .limit    (PU_LIM),
        .at_limit (pu_done)
    );

    // Exit wait, sized by the mode that was left.
    logic ex_step, ex_done;
    logic [CW-1:0] ex_lim;
    assign ex_step = (mode_q == MODE_EXIT);
    assign ex_lim  = exit_sr_q ? SR_LIM : PD_LIM;

    lpm_span_cnt #(.W(CW)) u_ex_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (!ex_step),
        .step     (ex_step),
        .limit    (ex_lim),
        .at_limit (ex_done)
    );

    always_comb begin
        mode_d    = mode_q;
        ill_d     = 1'b0;
        exit_sr_d = exit_sr_q;
        unique case (mode_q)
            MODE_PWRUP: begin
                if (pu_step && pu_done) mode_d = MODE_NORMAL;
            end
            MODE_NORMAL: begin
                if (ev.fall) begin
                    if (cmd == CMD_REFRESH && all_idle_i) mode_d = MODE_SREF;
                    else if (quiet)                      mode_d = MODE_PDOWN;
                    else                                 ill_d  = 1'b1;
                end
            end
            MODE_PDOWN, MODE_SREF: begin
                if (ev.rise) begin
                    mode_d    = MODE_EXIT;
                    exit_sr_d = (mode_q == MODE_SREF);
                    ill_d     = !quiet;
                end
            end
            MODE_EXIT: begin
                ill_d = !quiet;
                if (ex_done) mode_d = MODE_NORMAL;
            end
            default: mode_d = MODE_PWRUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_PWRUP;
            ill_q     <= 1'b0;
            exit_sr_q <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            ill_q     <= ill_d;
            exit_sr_q <= exit_sr_d;
        end
    end

    assign mode_o       = mode_q;
    assign illegal_o    = ill_q;
    assign cmd_accept_o = (mode_q == MODE_NORMAL);
    assign dq_hiz_o     = !cke_prev || (mode_q == MODE_PWRUP);
endmodule

// File: rtl/cke_lpm_chk.sv
module cke_lpm_chk (
    input logic       clk,
    input logic       rst,
    input logic       cke_i,
    input logic [2:0] cmd_i,
    input logic       all_idle_i,
    input logic [2:0] mode_o,
    input logic       dq_hiz_o,
    input logic       illegal_o
);
    logic chk_prev;
    always_ff @(posedge clk) begin
        if (rst) chk_prev <= 1'b0;
        else     chk_prev <= cke_i;
    end

    // R5: forbidden command on a fall flags illegal and keeps normal mode
    a_r5_fall_illegal: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd1 && chk_prev && !cke_i && cmd_i >= 3'd3)
        |=> (illegal_o && mode_o == 3'd1));

    // R6: low-power mode holds while clock-enable stays low
    a_r6_low_hold: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 3'd2 || mode_o == 3'd3) && !cke_i)
        |=> ($stable(mode_o) && !illegal_o));

    // R4: self refresh entered only with all banks idle
    a_r4_sref_idle: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd3 && $past(mode_o) != 3'd3) |-> $past(all_idle_i));

    // R10: pins high impedance after clock-enable sampled low
    a_r10_hiz: assert property (@(posedge clk) disable iff (rst)
        !chk_prev |-> dq_hiz_o);

    // R7: exit wait reached only from a low-power mode
    a_r7_exit_src: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd4 && $past(mode_o) != 3'd4)
        |-> ($past(mode_o) == 3'd2 || $past(mode_o) == 3'd3));

    // R2: power-up wait ends only on a deselect cycle with clock-enable high
    a_r2_pwrup_end: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd1 && $past(mode_o) == 3'd0)
        |-> ($past(cke_i) && $past(cmd_i) == 3'd0));
endmodule

bind cke_lpm_ctrl cke_lpm_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cke_i      (cke_i),
    .cmd_i      (cmd_i),
    .all_idle_i (all_idle_i),
    .mode_o     (mode_o),
    .dq_hiz_o   (dq_hiz_o),
    .illegal_o  (illegal_o)
);

// File: tb/sim_cke_lpm_ctrl.sv
module sim_cke_lpm_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       idle = 1'b1;
    logic [2:0] mode;
    logic       acc, hiz, ill;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cke_lpm_ctrl u0 (
        .clk          (clk),
        .rst          (rst),
        .cke_i        (cke),
        .cmd_i        (cmd),
        .all_idle_i   (idle),
        .mode_o       (mode),
        .cmd_accept_o (acc),
        .dq_hiz_o     (hiz),
        .illegal_o    (ill)
    );

    // [9] cke, [8:6] cmd, [5] idle, [4:2] expected mode, [1] illegal, [0] hiz
    localparam logic [9:0] VEC [12] = '{
        {1'b1, 3'd1, 1'b1, 3'd1, 1'b0, 1'b0},
        {1'b0, 3'd3, 1'b1, 3'd1, 1'b1, 1'b1},
        {1'b1, 3'd1, 1'b1, 3'd1, 1'b0, 1'b0},
        {1'b0, 3'd1, 1'b1, 3'd2, 1'b0, 1'b1},
        {1'b0, 3'd4, 1'b1, 3'd2, 1'b0, 1'b1},
        {1'b1, 3'd1, 1'b1, 3'd4, 1'b0, 1'b0},
        {1'b1, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0},
        {1'b0, 3'd2, 1'b0, 3'd1, 1'b1, 1'b1},
        {1'b1, 3'd1, 1'b1, 3'd1, 1'b0, 1'b0},
        {1'b0, 3'd2, 1'b1, 3'd3, 1'b0, 1'b1},
        {1'b0, 3'd5, 1'b1, 3'd3, 1'b0, 1'b1},
        {1'b1, 3'd3, 1'b1, 3'd4, 1'b1, 1'b0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 2, 8: return "R11";
            1, 7:    return "R5";
            3:       return "R3";
            4, 10:   return "R6";
            5, 6:    return "R7";
            9:       return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(logic c, logic [2:0] k, logic i);
        cke  = c;
        cmd  = k;
        idle = i;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 mode", mode, 0);
        chk("R1 accept", acc, 0);
        chk("R1 illegal", ill, 0);
        chk("R10 hiz in power-up", hiz, 1);
        rst = 1'b0;
        tick(1'b0, 3'd0, 1'b1);
        chk("R1 mode after release", mode, 0);

        // R2: broken run restarts the hold count
        for (int n = 0; n < 150; n++) tick(1'b1, 3'd0, 1'b1);
        tick(1'b1, 3'd1, 1'b1);
        for (int n = 0; n < 199; n++) tick(1'b1, 3'd0, 1'b1);
        chk("R2 still waiting after 199", mode, 0);
        chk("R11 no accept in power-up", acc, 0);
        tick(1'b1, 3'd0, 1'b1);
        chk("R2 normal after 200", mode, 1);

        // Table walk
        for (int i = 0; i < 12; i++) begin
            logic [9:0] v;
            v = VEC[i];
            tick(v[9], v[8:6], v[5]);
            chk({vec_tag(i), " mode"}, mode, v[4:2]);
            chk({vec_tag(i), " illegal"}, ill, v[1]);
            chk("R10 hiz", hiz, v[0]);
            chk("R11 accept", acc, (v[4:2] == 3'd1) ? 1 : 0);
        end

        // R8 / R9: long self-refresh exit wait with a command injected
        for (int k = 1; k <= 198; k++) begin
            if (k == 100) begin
                tick(1'b1, 3'd4, 1'b1);
                chk("R9 illegal during exit wait", ill, 1);
                chk("R9 exit continues", mode, 4);
            end else begin
                tick(1'b1, 3'd0, 1'b1);
            end
        end
        chk("R8 still in exit wait", mode, 4);
        tick(1'b1, 3'd1, 1'b1);
        chk("R8 normal after exit wait", mode, 1);
        chk("R11 accept after exit", acc, 1);
        chk("R9 no illegal on quiet", ill, 0);

        // R1: reset mid-run
        rst = 1'b1;
        tick(1'b1, 3'd0, 1'b1);
        rst = 1'b0;
        chk("R1 mode after mid reset", mode, 0);
        chk("R1 accept after mid reset", acc, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule